// File: doc/BRIEF.md
# Dimmable Multiplexed Seven-Segment Scanner

This block drives eight common-cathode seven-segment digits one at a time. It takes three two-digit packed-BCD fields from an upstream display selector. These are hours/minutes/seconds for the clock view, or minutes/seconds/hundredths for the stopwatch view. A slow scan strobe, nominally 5 kHz, steps a scan position through the eight digits. The block drives a one-hot digit select and the matching segment pattern.

Every digit slot is divided into a fixed number of sub-steps. The selected digit is lit only during the first (level+1) sub-steps of its slot, so a small level register sets the perceived brightness. While a brightness-adjust enable from the mode controller is high, each rising edge of the adjust key raises the level by one step. Past the top level it wraps to the dimmest visible level.

Top module: `led_scan_dimmer`

## Requirements
- R1: A synchronous reset sets the scan position to 0, the sub-step counter to 0 and the brightness level to its maximum (SUB_STEPS-1, which is 7 by default).
- R2: Each clock with `tick` high advances the sub-step counter. After SUB_STEPS sub-steps, the counter returns to 0 and the scan position advances, wrapping from 7 to 0. When `dig_o` is lit, it is one-hot with bit p set for scan position p.
- R3: The scan positions show the following fields. Position 0 is `fld_hi[7:4]` and position 1 is `fld_hi[3:0]`. Position 3 is `fld_mid[7:4]` and position 4 is `fld_mid[3:0]`. Position 6 is `fld_lo[7:4]` and position 7 is `fld_lo[3:0]`. Positions 2 and 5 are blank separators with all segments off.
- R4: `seg_o` bit 0 is segment a through bit 6, which is segment g; a 1 lights the segment. Digits 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).
- R5: A BCD nibble with a value from 10 to 15 shows all segments off.
- R6: When the sub-step count exceeds the brightness level, both `dig_o` and `seg_o` are all zero.
- R7: A rising edge of `adj_key` while `adj_en` is high raises the level by one on the next clock.
- R8: A step taken at the maximum level sets the level to 1, so the level is never 0.
- R9: `adj_key` edges while `adj_en` is low leave the level unchanged.
- R10: A key held high gives only one step, because the edge is detected against a registered copy of the key.
- R11: With `tick` low, the scan position and sub-step counter hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Scan strobe, one clock wide |
| adj_en | input | 1 | Brightness-adjust mode enable |
| adj_key | input | 1 | Debounced brightness step key |
| fld_hi | input | 8 | Left field, packed BCD |
| fld_mid | input | 8 | Middle field, packed BCD |
| fld_lo | input | 8 | Right field, packed BCD |
| seg_o | output | 7 | Segment drive, bit 0 = a, bit 6 = g |
| dig_o | output | 8 | One-hot digit select |

## Verification
The bench builds the block with its default of eight sub-steps per slot. With that value, one full frame takes 64 strobes and every brightness level can be reached in a few key presses. The bench can therefore cover the following within a short run: complete scan-position wraps, the level wrap from 7 back to 1, the narrow two-sub-step window at level 1, and a held key.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
  localparam int NUM_POS = 8;
  localparam int POS_W   = $clog2(NUM_POS);

  typedef logic [6:0] seg_t;

  typedef struct packed {
    logic       blank;
    logic [3:0] nib;
  } slot_src_t;

  // bit0 = a ... bit6 = g, active high
  function automatic seg_t bcd_glyph(input logic [3:0] d);
    seg_t g;
    case (d)
      4'd0: g = 7'h3F;
      4'd1: g = 7'h06;
      4'd2: g = 7'h5B;
      4'd3: g = 7'h4F;
      4'd4: g = 7'h66;
      4'd5: g = 7'h6D;
      4'd6: g = 7'h7D;
      4'd7: g = 7'h07;
      4'd8: g = 7'h7F;
      4'd9: g = 7'h6F;
      default: g = 7'h00;
    endcase
    return g;
  endfunction

  // Fixed left-to-right layout: HH _ MM _ LL
  function automatic slot_src_t pos_source(input logic [POS_W-1:0] p,
                                           input logic [7:0] hi,
                                           input logic [7:0] mid,
                                           input logic [7:0] lo);
    slot_src_t s;
    s.blank = 1'b0;
    s.nib   = 4'd0;
    case (p)
      3'd0: s.nib = hi[7:4];
      3'd1: s.nib = hi[3:0];
      3'd3: s.nib = mid[7:4];
      3'd4: s.nib = mid[3:0];
      3'd6: s.nib = lo[7:4];
      3'd7: s.nib = lo[3:0];
      default: s.blank = 1'b1;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int SUB_STEPS = 8,
  localparam int SUB_W = $clog2(SUB_STEPS),
  localparam int POS_W = led_scan_pkg::POS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [SUB_W-1:0] sub_q,
  output logic [POS_W-1:0] pos_q
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_STEPS - 1);

  logic slot_end;
  assign slot_end = (sub_q == SUB_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q <= '0;
      pos_q <= '0;
    end else if (tick) begin
      if (slot_end) begin
        sub_q <= '0;
        pos_q <= pos_q + POS_W'(1);
      end else begin
        sub_q <= sub_q + SUB_W'(1);
      end
    end
  end
endmodule

// File: rtl/bright_ctrl.sv
module bright_ctrl #(
  parameter int LVL_W = 3,
  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adj_en,
  input  logic             adj_key,
  output logic [LVL_W-1:0] level_q
);
  logic key_prev_q;
  logic key_rise;
  logic step_evt;

  function automatic logic [LVL_W-1:0] raise_level(input logic [LVL_W-1:0] l);
    return (l == LVL_MAX) ? LVL_W'(1) : l + LVL_W'(1);
  endfunction

  assign key_rise = adj_key & ~key_prev_q;
  assign step_evt = adj_en & key_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      key_prev_q <= 1'b0;
      level_q    <= LVL_MAX;
    end else begin
      key_prev_q <= adj_key;
      if (step_evt) level_q <= raise_level(level_q);
    end
  end
endmodule

// File: rtl/digit_drive.sv
module digit_drive #(
  parameter int W = 3,
  localparam int POS_W = led_scan_pkg::POS_W,
  localparam int NPOS  = led_scan_pkg::NUM_POS
) (
  input  logic [POS_W-1:0] pos,
  input  logic [W-1:0]     sub,
  input  logic [W-1:0]     level,
  input  logic [7:0]       hi,
  input  logic [7:0]       mid,
  input  logic [7:0]       lo,
  output logic [6:0]       seg,
  output logic [NPOS-1:0]  dig
);
  import led_scan_pkg::*;

  slot_src_t src;
  logic      lit;

  assign src = pos_source(pos, hi, mid, lo);
  assign lit = (sub <= level);

  always_comb begin
    dig = '0;
    seg = '0;
    if (lit) begin
      dig = NPOS'(1) << pos;
      if (!src.blank) seg = bcd_glyph(src.nib);
    end
  end
endmodule

// File: rtl/led_scan_dimmer.sv
module led_scan_dimmer #(
  parameter int SUB_STEPS = 8,
  localparam int SUB_W = $clog2(SUB_STEPS),
  localparam int POS_W = led_scan_pkg::POS_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       adj_en,
  input  logic       adj_key,
  input  logic [7:0] fld_hi,
  input  logic [7:0] fld_mid,
  input  logic [7:0] fld_lo,
  output logic [6:0] seg_o,
  output logic [7:0] dig_o
);
  logic [SUB_W-1:0] sub_q;
  logic [POS_W-1:0] pos_q;
  logic [SUB_W-1:0] level_q;

  scan_timer #(.SUB_STEPS(SUB_STEPS)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .sub_q(sub_q), .pos_q(pos_q)
  );

  bright_ctrl #(.LVL_W(SUB_W)) u_bright (
    .clk(clk), .rst(rst), .adj_en(adj_en), .adj_key(adj_key), .level_q(level_q)
  );

  digit_drive #(.W(SUB_W)) u_drive (
    .pos(pos_q), .sub(sub_q), .level(level_q),
    .hi(fld_hi), .mid(fld_mid), .lo(fld_lo),
    .seg(seg_o), .dig(dig_o)
  );
endmodule

// File: rtl/led_scan_dimmer_chk.sv
module led_scan_dimmer_chk #(
  parameter int SUB_W = 3,
  parameter int POS_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [SUB_W-1:0] sub_q,
  input logic [POS_W-1:0] pos_q,
  input logic [SUB_W-1:0] level_q,
  input logic [6:0]       seg_o,
  input logic [7:0]       dig_o
);
  localparam logic [SUB_W-1:0] SMAX = {SUB_W{1'b1}};

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (pos_q == '0 && sub_q == '0 && level_q == SMAX));

  p_pos_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && sub_q == SMAX) |=> (pos_q == $past(pos_q) + POS_W'(1) && sub_q == '0));

  p_dig_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dig_o));

  p_dark_slot_r6: assert property (@(posedge clk) disable iff (rst)
    (sub_q > level_q) |-> (dig_o == '0 && seg_o == '0));

  p_scan_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(pos_q) && $stable(sub_q)));
endmodule

module bright_ctrl_chk #(
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             adj_en,
  input logic             step_evt,
  input logic [LVL_W-1:0] level_q
);
  localparam logic [LVL_W-1:0] LMAX = {LVL_W{1'b1}};

  p_step_up_r7: assert property (@(posedge clk) disable iff (rst)
    (step_evt && level_q != LMAX) |=> level_q == $past(level_q) + LVL_W'(1));

  p_wrap_low_r8: assert property (@(posedge clk) disable iff (rst)
    (step_evt && level_q == LMAX) |=> level_q == LVL_W'(1));

  p_never_dark_r8: assert property (@(posedge clk) disable iff (rst)
    level_q != '0);

  p_locked_r9: assert property (@(posedge clk) disable iff (rst)
    !adj_en |=> $stable(level_q));
endmodule

bind led_scan_dimmer led_scan_dimmer_chk #(.SUB_W(SUB_W), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .sub_q(sub_q), .pos_q(pos_q),
  .level_q(level_q), .seg_o(seg_o), .dig_o(dig_o)
);

bind bright_ctrl bright_ctrl_chk #(.LVL_W(LVL_W)) u_bchk (
  .clk(clk), .rst(rst), .adj_en(adj_en), .step_evt(step_evt), .level_q(level_q)
);

// File: tb/tb_led_scan_dimmer.sv
module tb_led_scan_dimmer;
  logic       clk = 1'b0;
  logic       rst, tick, adj_en, adj_key;
  logic [7:0] fld_hi, fld_mid, fld_lo;
  logic [6:0] seg_o;
  logic [7:0] dig_o;

  led_scan_dimmer dut (
    .clk(clk), .rst(rst), .tick(tick), .adj_en(adj_en), .adj_key(adj_key),
    .fld_hi(fld_hi), .fld_mid(fld_mid), .fld_lo(fld_lo),
    .seg_o(seg_o), .dig_o(dig_o)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [7:0] dig;
    logic [6:0] seg;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  // bench model state
  int m_sub, m_pos, m_lvl;
  bit m_prev;

  function automatic logic [6:0] glyph_of(input logic [3:0] d);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                           7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return (d < 10) ? t[d] : 7'h00;
  endfunction

  function automatic logic [6:0] pos_glyph(input int p);
    case (p)
      0: return glyph_of(fld_hi[7:4]);
      1: return glyph_of(fld_hi[3:0]);
      3: return glyph_of(fld_mid[7:4]);
      4: return glyph_of(fld_mid[3:0]);
      6: return glyph_of(fld_lo[7:4]);
      7: return glyph_of(fld_lo[3:0]);
      default: return 7'h00;
    endcase
  endfunction

  task automatic step(input bit r, input bit t, input bit e, input bit k, input string tag);
    exp_t x;
    rst = r; tick = t; adj_en = e; adj_key = k;
    @(posedge clk);
    if (r) begin
      m_sub = 0; m_pos = 0; m_lvl = 7; m_prev = 0;
    end else begin
      if (e && k && !m_prev) m_lvl = (m_lvl == 7) ? 1 : m_lvl + 1;
      m_prev = k;
      if (t) begin
        m_sub = m_sub + 1;
        if (m_sub == 8) begin
          m_sub = 0;
          m_pos = (m_pos + 1) % 8;
        end
      end
    end
    if (m_sub <= m_lvl) begin
      x.dig = 8'(1 << m_pos);
      x.seg = pos_glyph(m_pos);
    end else begin
      x.dig = 8'h00;
      x.seg = 7'h00;
    end
    x.tag = tag;
    exp_q.push_back(x);
    @(negedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (dig_o !== e.dig || seg_o !== e.seg) begin
        n_fail++;
        $display("FAIL %s: dig=%h seg=%h expected dig=%h seg=%h",
                 e.tag, dig_o, seg_o, e.dig, e.seg);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    fld_hi = 8'h12; fld_mid = 8'h34; fld_lo = 8'h56;
    // R1: reset state
    repeat (3) step(1, 0, 0, 0, "R1 reset");
    // R2 R3 R4: full frame at full brightness, clock-style fields
    repeat (64) step(0, 1, 0, 0, "R2 R3 R4 scan");
    // stopwatch-style digits plus R5 invalid codes on the right field
    fld_hi = 8'h07; fld_mid = 8'h89; fld_lo = 8'hAF;
    repeat (64) step(0, 1, 0, 0, "R5 invalid bcd");
    fld_lo = 8'hC3;
    repeat (64) step(0, 1, 0, 0, "R5 tens invalid");
    // R11: no strobe, scan holds
    repeat (12) step(0, 0, 0, 0, "R11 hold");
    // R9: key edges without adjust enable
    for (int i = 0; i < 6; i++) begin
      step(0, 1, 0, 1, "R9 locked");
      step(0, 1, 0, 0, "R9 locked");
    end
    repeat (16) step(0, 1, 0, 0, "R9 level kept");
    // R8: wrap from 7 to 1, then R10 held key and R6 dark sub-steps
    step(0, 1, 1, 1, "R8 wrap");
    repeat (40) step(0, 1, 1, 1, "R10 held key");
    repeat (4) step(0, 1, 1, 0, "R6 dim");
    // R7: each fresh edge raises the level by one
    for (int n = 0; n < 3; n++) begin
      step(0, 1, 1, 1, "R7 step");
      repeat (20) step(0, 1, 1, 0, "R7 R6 duty");
    end
    // R1: reset mid-run restores full brightness and position 0
    step(1, 1, 1, 0, "R1 rerun");
    repeat (16) step(0, 1, 0, 0, "R1 after");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule